// File: doc/BRIEF.md
# Fractional Clock-Enable Divider with Triggered Reload

This block turns a free-running input clock into a train of single-cycle enable pulses. Their average rate equals the input rate divided by a divisor that has both a whole and a fractional part. The divisor is held in a register field of parameterised width `W` and position `SHIFT` inside a 32-bit divider word. The field carries `F` fractional bits and is offset by one whole unit: a field value `r` stands for the divisor `(r + 2^F) / 2^F`. A phase accumulator adds `2^F` on every input cycle. Whenever the sum reaches the scaled divisor `r + 2^F`, the block emits a pulse and subtracts that scaled divisor.

Software first stages a new field value. It then starts a reload by writing 1 to the trigger bit of the control word. A small sequencer carries out the reload in three states:
- `SEQ_IDLE` waits for a trigger.
- `SEQ_RAISE` holds the output gate on until its status reports enabled. It is entered from `SEQ_IDLE` when the trigger arrives with the gate status off.
- `SEQ_ALIGN` waits for a pulse boundary with the gate status on. It is entered from `SEQ_IDLE` when the trigger arrives with the status already on, or from `SEQ_RAISE` once the status rises.

At that boundary the staged value becomes the active divisor, the phase restarts from zero, and the sequencer returns to `SEQ_IDLE`. The trigger bit reads 1 in `SEQ_RAISE` and `SEQ_ALIGN`.

The output gate has a software enable bit and a separate status bit. The status bit follows the effective enable request a fixed number of cycles later. The sequencer forces the request on for the whole reload, so a gate that software left off comes back on for the reload and then returns to off. A build option makes the gate impossible to disable.

Top module: `fdiv_unit`

## Requirements
- R1: With active field r, the pulse output, while the gate status is on, gives exactly N·2^F pulses in every window of N·(r + 2^F) consecutive input cycles; a field of 0 pulses on every cycle.
- R2: The all-ones field (2^W − 1) gives the largest divisor, (2^W − 1 + 2^F)/2^F.
- R3: Address 0 reads and writes the whole 32-bit divider word. A write to address 2 replaces only bits [SHIFT+W−1:SHIFT] with wr_data[W−1:0] and leaves every other bit of the word unchanged. Reading address 2 returns the staged field right-aligned.
- R4: A staged field has no effect on the pulse rate or on the active field, which reads right-aligned at address 3, until a trigger is applied.
- R5: Writing address 1 with bit 2 set while idle starts a reload, and control bit 2 then reads 1. Writing address 1 with bit 2 clear starts nothing. A trigger written while a reload is in progress is ignored and queues nothing.
- R6: The active field changes only on a cycle that has a raw pulse with the gate status on, during a reload. Control bit 2 reads 0 from the following cycle.
- R7: During a reload the gate request is held on. If control bit 0 was written as 0, the request returns to off afterwards and bit 0 still reads 0.
- R8: Gate status, control bit 1, equals the effective gate request as it stood GATE_DLY cycles earlier.
- R9: clk_en_o pulses only while the gate status is on.
- R10: When NO_DISABLE is set, the gate request stays on even after control bit 0 is written as 0, and control bit 0 reads 1.
- R11: The phase accumulator always stays below the scaled active divisor.
- R12: After reset the divider word, the staged and active fields and the control bits all read 0, and clk_en_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock being divided |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for reads and writes (0 word, 1 control, 2 field, 3 active) |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data for `addr`, combinational |
| clk_en_o | output | 1 | Divided enable pulse, gated by the gate status |

## Verification
On every cycle, the assertions check the phase bound, the gating of the output by the status bit, the status lag against the gate request, and the forced gate during a reload. They also check that the active field changes only at a gated pulse of a reload, and that divide-by-one pulses continuously. Only the bench's scenarios can show the following:
- pulse counts over whole periods for fractional and maximum divisors;
- that a staged field stays inert until triggered;
- that field writes preserve the surrounding bits;
- that a repeated trigger during a reload is dropped;
- that a gate left off is restored to off after a reload.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

    // Reload sequencer states
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_RAISE = 2'd1,
        SEQ_ALIGN = 2'd2
    } seq_state_e;

    // Register addresses
    localparam logic [1:0] A_DIVREG = 2'd0;
    localparam logic [1:0] A_CTRL   = 2'd1;
    localparam logic [1:0] A_FIELD  = 2'd2;
    localparam logic [1:0] A_ACTIVE = 2'd3;

    // Control word bit positions
    localparam int CB_EN   = 0;
    localparam int CB_STAT = 1;
    localparam int CB_TRIG = 2;

endpackage

// File: rtl/fdiv_regs.sv
module fdiv_regs
    import fdiv_pkg::*;
#(
    parameter int W     = 6,
    parameter int SHIFT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    addr,
    input  logic [31:0]   wr_data,
    output logic [31:0]   div_word,
    output logic [W-1:0]  pend_field,
    output logic          sw_en,
    output logic          trig_req
);
    localparam logic [31:0] FMASK = ((32'd1 << W) - 32'd1) << SHIFT;

    logic [31:0] field_ins;

    // Field write inserts the low W bits at SHIFT, keeps the rest (R3)
    assign field_ins = (div_word & ~FMASK) | ((32'(wr_data[W-1:0])) << SHIFT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_word <= '0;
            sw_en    <= 1'b0;
        end else if (wr_en) begin
            case (addr)
                A_DIVREG: div_word <= wr_data;
                A_FIELD:  div_word <= field_ins;
                A_CTRL:   sw_en    <= wr_data[CB_EN];
                default:  ;
            endcase
        end
    end

    assign pend_field = div_word[SHIFT +: W];
    assign trig_req   = wr_en && (addr == A_CTRL) && wr_data[CB_TRIG];

endmodule

// File: rtl/fdiv_gate.sv
module fdiv_gate #(
    parameter int DLY    = 3,
    parameter bit NO_DIS = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_en,
    input  logic force_on,
    output logic req,
    output logic status
);
    logic [DLY-1:0] line_q;

    generate
        if (NO_DIS) begin : g_locked
            logic unused_en;
            assign unused_en = sw_en | force_on;
            assign req = 1'b1;
        end else begin : g_normal
            assign req = sw_en | force_on;
        end
    endgenerate

    // Status lags the request by DLY cycles (R8)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
        end else begin
            line_q[0] <= req;
            for (int i = 1; i < DLY; i++) begin
                line_q[i] <= line_q[i-1];
            end
        end
    end

    assign status = line_q[DLY-1];

endmodule

// File: rtl/fdiv_accum.sv
module fdiv_accum #(
    parameter int F = 2,
    parameter int W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [W-1:0]    new_field,
    output logic            raw_pulse,
    output logic [W-1:0]    act_field,
    output logic [W+1:0]    acc,
    output logic [W+1:0]    scaled_div
);
    localparam int AW = W + 2;
    localparam logic [AW-1:0] STEP = AW'(1) << F;

    logic [AW-1:0] sum;

    // The field is offset by one whole unit: scaled divisor = r + 2^F
    assign scaled_div = AW'(act_field) + STEP;
    assign sum        = acc + STEP;
    assign raw_pulse  = (sum >= scaled_div);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_field <= '0;
            acc       <= '0;
        end else if (load) begin
            act_field <= new_field;
            acc       <= '0;
        end else if (raw_pulse) begin
            acc <= sum - scaled_div;
        end else begin
            acc <= sum;
        end
    end

endmodule

// File: rtl/fdiv_seq.sv
module fdiv_seq
    import fdiv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig_req,
    input  logic gate_on,
    input  logic raw_pulse,
    output logic busy,
    output logic load,
    output logic force_on
);
    seq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (trig_req) begin
                    state_d = gate_on ? SEQ_ALIGN : SEQ_RAISE;
                end
            end
            SEQ_RAISE: begin
                if (gate_on) begin
                    state_d = SEQ_ALIGN;
                end
            end
            SEQ_ALIGN: begin
                if (gate_on && raw_pulse) begin
                    state_d = SEQ_IDLE;
                end
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    always_comb begin
        busy     = (state_q != SEQ_IDLE);
        force_on = busy;
        load     = (state_q == SEQ_ALIGN) && gate_on && raw_pulse;
    end

endmodule

// File: rtl/fdiv_unit.sv
module fdiv_unit
    import fdiv_pkg::*;
#(
    parameter int F          = 2,
    parameter int W          = 6,
    parameter int SHIFT      = 4,
    parameter int GATE_DLY   = 3,
    parameter bit NO_DISABLE = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  addr,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        clk_en_o
);
    logic [31:0]  div_word;
    logic [W-1:0] pend_field;
    logic [W-1:0] act_field;
    logic [W+1:0] acc_val;
    logic [W+1:0] scaled_div;
    logic         sw_en, trig_req;
    logic         raw_pulse, gate_req, gate_status;
    logic         busy, load, force_on;

    fdiv_regs #(.W(W), .SHIFT(SHIFT)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .div_word(div_word), .pend_field(pend_field),
        .sw_en(sw_en), .trig_req(trig_req)
    );

    fdiv_gate #(.DLY(GATE_DLY), .NO_DIS(NO_DISABLE)) u_gate (
        .clk(clk), .rst_n(rst_n), .sw_en(sw_en), .force_on(force_on),
        .req(gate_req), .status(gate_status)
    );

    fdiv_accum #(.F(F), .W(W)) u_accum (
        .clk(clk), .rst_n(rst_n), .load(load), .new_field(pend_field),
        .raw_pulse(raw_pulse), .act_field(act_field), .acc(acc_val),
        .scaled_div(scaled_div)
    );

    fdiv_seq u_seq (
        .clk(clk), .rst_n(rst_n), .trig_req(trig_req), .gate_on(gate_status),
        .raw_pulse(raw_pulse), .busy(busy), .load(load), .force_on(force_on)
    );

    assign clk_en_o = raw_pulse & gate_status;

    always_comb begin
        rd_data = '0;
        unique case (addr)
            A_DIVREG: rd_data = div_word;
            A_CTRL: begin
                rd_data[CB_EN]   = sw_en | NO_DISABLE;
                rd_data[CB_STAT] = gate_status;
                rd_data[CB_TRIG] = busy;
            end
            A_FIELD:  rd_data = 32'(pend_field);
            A_ACTIVE: rd_data = 32'(act_field);
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/fdiv_checker.sv
module fdiv_checker #(
    parameter int F          = 2,
    parameter int W          = 6,
    parameter int GATE_DLY   = 3,
    parameter bit NO_DISABLE = 1'b0
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W+1:0] acc_val,
    input logic [W+1:0] scaled_div,
    input logic [W-1:0] act_field,
    input logic         raw_pulse,
    input logic         gate_req,
    input logic         gate_status,
    input logic         busy,
    input logic         clk_en_o
);
    localparam int CW = $clog2(GATE_DLY + 1) + 1;

    logic          req_q;
    logic [CW-1:0] lag_cnt;

    // Cycles the gate request has been steady
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q   <= 1'b0;
            lag_cnt <= CW'(GATE_DLY);
        end else begin
            req_q <= gate_req;
            if (gate_req != req_q) begin
                lag_cnt <= CW'(1);
            end else if (lag_cnt < CW'(GATE_DLY)) begin
                lag_cnt <= lag_cnt + CW'(1);
            end
        end
    end

    a_r11_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
        acc_val < scaled_div);

    a_r6_apply_at_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_field) |-> $past(raw_pulse && gate_status && busy));

    a_r6_trigger_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_field) |-> !busy);

    a_r7_gate_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> gate_req);

    a_r8_status_lag: assert property (@(posedge clk) disable iff (!rst_n)
        (lag_cnt >= CW'(GATE_DLY)) |-> (gate_status == req_q));

    a_r9_output_gated: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_o |-> gate_status);

    a_r1_unity_rate: assert property (@(posedge clk) disable iff (!rst_n)
        (act_field == '0 && gate_status) |-> clk_en_o);

    a_r10_no_disable: assert property (@(posedge clk) disable iff (!rst_n)
        (NO_DISABLE != 1'b0) |-> gate_req);

endmodule

bind fdiv_unit fdiv_checker #(
    .F(F), .W(W), .GATE_DLY(GATE_DLY), .NO_DISABLE(NO_DISABLE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_val(acc_val), .scaled_div(scaled_div),
    .act_field(act_field), .raw_pulse(raw_pulse), .gate_req(gate_req),
    .gate_status(gate_status), .busy(busy), .clk_en_o(clk_en_o)
);

// File: tb/sim_fdiv_unit.sv
module sim_fdiv_unit;
    import fdiv_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DLY        = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        clk_en_o;

    logic        wr1_en = 1'b0;
    logic [1:0]  addr1 = 2'd0;
    logic [31:0] wd1 = '0;
    logic [31:0] rd1;
    logic        ce1;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fdiv_unit #(.F(2), .W(6), .SHIFT(4), .GATE_DLY(DLY), .NO_DISABLE(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .clk_en_o(clk_en_o)
    );

    fdiv_unit #(.F(2), .W(6), .SHIFT(4), .GATE_DLY(DLY), .NO_DISABLE(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr1_en), .addr(addr1),
        .wr_data(wd1), .rd_data(rd1), .clk_en_o(ce1)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic count_pulses(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
            c += int'(clk_en_o);
        end
    endtask

    task automatic wait_idle(output bit seen_stat);
        logic [31:0] v;
        bit ok = 1'b0;
        seen_stat = 1'b0;
        for (int i = 0; i < 400; i++) begin
            bus_read(A_CTRL, v);
            if (v[CB_STAT]) seen_stat = 1'b1;
            if (!v[CB_TRIG]) begin
                ok = 1'b1;
                break;
            end
            @(negedge clk);
        end
        chk("R6 reload completes", 32'(ok), 32'd1);
    endtask

    task automatic apply(input logic [5:0] field, input bit en, output bit seen_stat);
        logic [31:0] v;
        bus_write(A_FIELD, 32'(field));
        bus_write(A_CTRL, 32'h4 | 32'(en));
        bus_read(A_CTRL, v);
        chk("R5 trigger reads busy", 32'(v[CB_TRIG]), 32'd1);
        wait_idle(seen_stat);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        int c;
        bus_read(A_DIVREG, v); chk("R12 word after reset", v, 32'd0);
        bus_read(A_CTRL, v);   chk("R12 control after reset", v, 32'd0);
        bus_read(A_ACTIVE, v); chk("R12 active after reset", v, 32'd0);
        count_pulses(10, c);   chk("R12 R9 no pulses with gate off", 32'(c), 32'd0);
    endtask

    task automatic t_field_write();
        logic [31:0] v;
        bus_write(A_DIVREG, 32'hFFFF_FFFF);
        bus_write(A_FIELD, 32'hFFFF_FF05);
        bus_read(A_DIVREG, v); chk("R3 field write keeps other bits", v, 32'hFFFF_FC5F);
        bus_read(A_FIELD, v);  chk("R3 staged field readback", v, 32'd5);
        bus_read(A_ACTIVE, v); chk("R4 active untouched by staging", v, 32'd0);
    endtask

    task automatic t_gate_lag();
        logic [31:0] v;
        bus_write(A_CTRL, 32'd1);
        bus_read(A_CTRL, v); chk("R8 status still off", 32'(v[CB_STAT]), 32'd0);
        repeat (DLY - 1) @(negedge clk);
        bus_read(A_CTRL, v); chk("R8 status off one cycle early", 32'(v[CB_STAT]), 32'd0);
        @(negedge clk);
        bus_read(A_CTRL, v); chk("R8 status on after lag", 32'(v[CB_STAT]), 32'd1);
    endtask

    task automatic t_unity_and_hold();
        int c;
        count_pulses(16, c); chk("R1 field 0 divides by one", 32'(c), 32'd16);
        count_pulses(24, c); chk("R4 staged field 5 not yet applied", 32'(c), 32'd24);
    endtask

    task automatic t_rates();
        logic [31:0] v;
        bit s;
        int c;
        apply(6'd4, 1'b1, s);
        bus_read(A_ACTIVE, v); chk("R6 active after reload", v, 32'd4);
        count_pulses(24, c);   chk("R1 divide by 2.0", 32'(c), 32'd12);
        apply(6'd2, 1'b1, s);
        count_pulses(24, c);   chk("R1 divide by 1.5", 32'(c), 32'd16);
        apply(6'd1, 1'b1, s);
        count_pulses(40, c);   chk("R1 divide by 1.25", 32'(c), 32'd32);
        apply(6'd63, 1'b1, s);
        count_pulses(134, c);  chk("R2 all-ones field divides by 16.75", 32'(c), 32'd8);
    endtask

    task automatic t_trigger_rules();
        logic [31:0] v;
        bit s;
        bit seen_busy = 1'b0;
        bus_write(A_FIELD, 32'd4);
        bus_write(A_CTRL, 32'd1);
        bus_read(A_CTRL, v);   chk("R5 write without trigger stays idle", 32'(v[CB_TRIG]), 32'd0);
        bus_read(A_ACTIVE, v); chk("R4 R5 active kept without trigger", v, 32'd63);
        bus_write(A_CTRL, 32'd5);
        bus_read(A_CTRL, v);   chk("R5 busy before repeat trigger", 32'(v[CB_TRIG]), 32'd1);
        bus_write(A_CTRL, 32'd5);
        wait_idle(s);
        bus_read(A_ACTIVE, v); chk("R6 staged field applied", v, 32'd4);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            bus_read(A_CTRL, v);
            if (v[CB_TRIG]) seen_busy = 1'b1;
        end
        chk("R5 repeat trigger during reload ignored", 32'(seen_busy), 32'd0);
    endtask

    task automatic t_gate_off_reload();
        logic [31:0] v;
        bit s;
        int c;
        bus_write(A_CTRL, 32'd0);
        repeat (DLY + 2) @(negedge clk);
        bus_read(A_CTRL, v); chk("R8 status off after disable", 32'(v[CB_STAT]), 32'd0);
        count_pulses(20, c); chk("R9 gate off blocks pulses", 32'(c), 32'd0);
        apply(6'd2, 1'b0, s);
        chk("R7 gate forced on during reload", 32'(s), 32'd1);
        bus_read(A_ACTIVE, v); chk("R6 reload with gate off applied", v, 32'd2);
        repeat (DLY + 2) @(negedge clk);
        bus_read(A_CTRL, v); chk("R7 gate back off after reload", v[1:0], 32'd0);
        count_pulses(24, c); chk("R7 R9 no pulses after restore", 32'(c), 32'd0);
        bus_write(A_CTRL, 32'd1);
        repeat (DLY + 2) @(negedge clk);
        count_pulses(24, c); chk("R1 rate after gated reload", 32'(c), 32'd16);
    endtask

    task automatic t_no_disable();
        int c = 0;
        wr1_en = 1'b1; addr1 = A_CTRL; wd1 = 32'd0;
        @(negedge clk);
        wr1_en = 1'b0;
        repeat (DLY + 3) @(negedge clk);
        #1;
        chk("R10 locked gate reads enabled", rd1[1:0], 32'd3);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            #1;
            c += int'(ce1);
        end
        chk("R10 locked gate keeps pulsing", 32'(c), 32'd8);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_field_write();
        t_gate_lag();
        t_unity_and_hold();
        t_rates();
        t_trigger_rules();
        t_gate_off_reload();
        t_no_disable();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule